// File: doc/BRIEF.md
# Gated Clock Divider Bank

This block takes two candidate clocks, forwards one of them, and derives a set of clock outputs from it in parallel: the full-rate clock (or half-rate, chosen at a pin) on channel 0 and the clock divided by 2, 4 and 8 on channels 1 to 3. Every channel drives several identical copies, so one block can feed several loads with the same phase.

A single output enable starts and stops all channels together. The enable is registered on the falling edge of the selected clock, so the channels can only be started or stopped while that clock is low. No output ever carries a pulse shorter than half a period of the selected clock. A stop does not reset the dividers. It freezes them, and a later start resumes from the frozen phase. An active-low master reset clears everything at once and needs no clock edge. The source select is meant to change only while the outputs are stopped.

Top module: `gated_div_bank`

## Requirements
- R1: With `src_sel` = 0 the channels are derived from `clk_a`; with `src_sel` = 1 they are derived from `clk_b`.
- R2: Channel c (1 ≤ c ≤ STAGES) toggles at 1/2^c of the selected clock rate. Channel 0 carries the selected clock when `half_sel` = 0 and the divide-by-2 clock when `half_sel` = 1.
- R3: Output bit c*COPIES+k is copy k of channel c, and all copies of a channel are identical at all times.
- R4: `out_en` takes effect only at the next falling edge of the selected clock. A change made while that clock is high leaves the outputs unchanged until then.
- R5: A rising edge of a slower channel always coincides with rising edges of every faster divided channel.
- R6: While the registered enable is low, every output is low and the divider phase is frozen. Once re-enabled, the outputs continue from the frozen phase.
- R7: While `rst_n` is low, every output is low within one time step, with no clock edge required. Reset also clears the divider phase and the registered enable.
- R8: No output pulse, high or low, is shorter than half a period of the selected clock. This holds across enable changes and across select changes made while disabled.
- R9: After reset and the first enable, every channel's first rising edge falls on the same rising edge of the selected clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Candidate clock 0 |
| clk_b | input | 1 | Candidate clock 1 |
| src_sel | input | 1 | Source select, 0 = clk_a, 1 = clk_b |
| out_en | input | 1 | Common output enable, sampled on the falling edge of the selected clock |
| half_sel | input | 1 | Channel 0 mode, 0 = full rate, 1 = half rate |
| rst_n | input | 1 | Asynchronous active-low master reset |
| clk_out | output | (STAGES+1)*COPIES | Channel clocks; bit c*COPIES+k is copy k of channel c |

## Verification
The bench uses the default STAGES = 3 and COPIES = 2, which gives eight output lines and a divider cycle of only eight states. Because the cycle is that short, a run of a few dozen cycles covers every divider phase. The bench sweeps both sources, both channel-0 modes and several pause lengths, so that stops and restarts happen at many different frozen phases. The two source clocks have different periods, so the measured output periods and the pulse-width monitor show which clock is actually driving the channels.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int unsigned DEF_STAGES = 3;
    localparam int unsigned DEF_COPIES = 2;

    typedef enum logic {
        SRC_A = 1'b0,
        SRC_B = 1'b1
    } src_e;

    typedef enum logic {
        CH0_FULL = 1'b0,
        CH0_HALF = 1'b1
    } ch0_mode_e;

    // flat position of copy k of channel c
    function automatic int unsigned out_index(int unsigned c, int unsigned k, int unsigned copies);
        return c * copies + k;
    endfunction

endpackage

// File: rtl/clk_src_sel.sv
module clk_src_sel
    import clkdiv_pkg::*;
(
    input  logic clk_a,
    input  logic clk_b,
    input  src_e sel,
    output logic clk_sel
);
    // static select: only switched while all dividers are stopped
    assign clk_sel = (sel == SRC_B) ? clk_b : clk_a;
endmodule

// File: rtl/en_sync.sv
module en_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic en_in,
    output logic en_q
);
    // falling-edge capture: gating changes only while the clock is low
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_in;
    end
endmodule

// File: rtl/phase_counter.sv
module phase_counter #(
    parameter int unsigned STAGES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [STAGES-1:0] cnt
);
    localparam logic [STAGES-1:0] ONE = STAGES'(1);

    // down-counter: every bit rises on the 0 -> all-ones wrap, aligning rising edges
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (adv) cnt <= cnt - ONE;
    end

    assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(cnt));

    assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (cnt != $past(cnt)));

    assert_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnt[STAGES-1]) |-> (&cnt));
endmodule

// File: rtl/gated_div_bank.sv
module gated_div_bank
    import clkdiv_pkg::*;
#(
    parameter int unsigned STAGES = DEF_STAGES,
    parameter int unsigned COPIES = DEF_COPIES
) (
    input  logic                           clk_a,
    input  logic                           clk_b,
    input  logic                           src_sel,
    input  logic                           out_en,
    input  logic                           half_sel,
    input  logic                           rst_n,
    output logic [(STAGES+1)*COPIES-1:0]   clk_out
);
    localparam int unsigned NCH = STAGES + 1;

    logic              clk_sel;
    logic              en_q;
    logic [STAGES-1:0] cnt;
    logic [NCH-1:0]    ch;
    ch0_mode_e         ch0_mode;

    assign ch0_mode = ch0_mode_e'(half_sel);

    clk_src_sel u_src (
        .clk_a   (clk_a),
        .clk_b   (clk_b),
        .sel     (src_e'(src_sel)),
        .clk_sel (clk_sel)
    );

    en_sync u_en (
        .clk   (clk_sel),
        .rst_n (rst_n),
        .en_in (out_en),
        .en_q  (en_q)
    );

    phase_counter #(.STAGES(STAGES)) u_cnt (
        .clk   (clk_sel),
        .rst_n (rst_n),
        .adv   (en_q),
        .cnt   (cnt)
    );

    // channel clocks, each gated by the falling-edge enable
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        if (c == 0) begin : g_first
            assign ch[c] = en_q & ((ch0_mode == CH0_HALF) ? cnt[0] : clk_sel);
        end else begin : g_div
            assign ch[c] = en_q & cnt[c-1];
        end
    end

    // fan-out of every channel to its copies
    for (genvar c = 0; c < NCH; c++) begin : g_fan
        for (genvar k = 0; k < COPIES; k++) begin : g_copy
            assign clk_out[out_index(c, k, COPIES)] = ch[c];
        end
    end

    assert_hold_low_R6: assert property (@(posedge clk_sel) disable iff (!rst_n)
        !en_q |-> (clk_out == '0));
endmodule

// File: tb/gated_div_bank_test.sv
`timescale 1ns/1ps
module gated_div_bank_test;
    localparam int unsigned STAGES = 3;
    localparam int unsigned COPIES = 2;
    localparam int unsigned NCH    = STAGES + 1;
    localparam int unsigned NOUT   = NCH * COPIES;
    localparam int unsigned DIV    = 1 << STAGES;
    localparam realtime PA = 10.0;   // 100 MHz
    localparam realtime PB = 16.0;

    logic clk_a = 0, clk_b = 0;
    logic src_sel = 0, out_en = 0, half_sel = 0, rst_n = 0;
    logic [NOUT-1:0] clk_out;
    logic bsel;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #(PA/2) clk_a = ~clk_a;
    always #(PB/2) clk_b = ~clk_b;
    assign bsel = src_sel ? clk_b : clk_a;

    gated_div_bank #(.STAGES(STAGES), .COPIES(COPIES)) uut (
        .clk_a(clk_a), .clk_b(clk_b), .src_sel(src_sel), .out_en(out_en),
        .half_sel(half_sel), .rst_n(rst_n), .clk_out(clk_out)
    );

    // requirement model: count of enabled rising edges, enable seen at falls
    int unsigned m_n = 0;
    logic        m_en = 0;
    always @(negedge bsel or negedge rst_n)
        if (!rst_n) m_en <= 0; else m_en <= out_en;
    always @(posedge bsel or negedge rst_n)
        if (!rst_n) m_n <= 0; else if (m_en) m_n <= m_n + 1;

    function automatic logic exp_ch(int c);
        int unsigned v;
        v = (DIV - (m_n % DIV)) % DIV;
        if (!m_en) return 1'b0;
        if (c == 0) return half_sel ? logic'(v & 1) : bsel;
        return logic'((v >> (c - 1)) & 1);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic chan(int c, int k);
        return clk_out[c*COPIES + k];
    endfunction

    // continuous comparison against the model after each selected-clock edge
    logic [NCH-1:0] prev_ch = '0;
    bit cmp_on = 0;
    always @(posedge bsel or negedge bsel) begin
        #1;
        if (cmp_on && rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                check("R2", chan(c, 0), exp_ch(c), $sformatf("channel %0d", c));
                for (int k = 1; k < COPIES; k++)
                    check("R3", chan(c, k), chan(c, 0), $sformatf("ch %0d copy %0d", c, k));
            end
            if (bsel) begin
                for (int c = 2; c < NCH; c++)
                    if (!prev_ch[c] && chan(c, 0))
                        for (int f = 1; f < c; f++)
                            check("R5", {prev_ch[f], chan(f, 0)}, 2'b01,
                                  $sformatf("ch %0d rise with ch %0d", f, c));
            end
            for (int c = 0; c < NCH; c++) prev_ch[c] = chan(c, 0);
        end
    end

    // pulse-width monitor on every output line
    int n_runt = 0;
    task automatic runt(int i, realtime w);
        n_runt++;
        n_bad++;
        $display("FAIL R8 runt on output %0d: actual width %0t expected >= %0t", i, w, PA/2);
    endtask
    for (genvar i = 0; i < NOUT; i++) begin : g_mon
        realtime last = 0.0;
        always @(clk_out[i]) begin
            if (rst_n && ($realtime - last) < (PA/2 - 0.5))
                runt(i, $realtime - last);
            last = $realtime;
        end
    end

    task automatic do_reset();
        @(posedge bsel); #2;
        rst_n = 0;
        #1 check("R7", clk_out, 0, "outputs during reset");
        #12;
        @(negedge bsel); #2;
        rst_n = 1;
    endtask

    task automatic measure(int c, realtime per, string req);
        realtime t0, t1;
        @(posedge clk_out[c*COPIES]); t0 = $realtime;
        @(posedge clk_out[c*COPIES]); t1 = $realtime;
        check(req, int'(t1 - t0), int'(per), $sformatf("period of channel %0d", c));
    endtask

    task automatic scenario(bit s, bit h, int pause);
        realtime p;
        out_en = 0;
        repeat (3) @(negedge bsel);
        #3;
        src_sel = s;          // switched while stopped
        half_sel = h;
        p = s ? PB : PA;
        repeat (2) @(negedge bsel);
        check("R8", clk_out, 0, "outputs after select change");
        do_reset();
        // enable while clock high: nothing changes before the falling edge
        @(posedge bsel); #1;
        out_en = 1;
        #1 check("R4", clk_out, 0, "before falling edge");
        @(negedge bsel);
        @(posedge bsel); #1;
        check("R9", clk_out, {NOUT{1'b1}}, "first rising edge after reset");
        measure(1, 2*p, "R1");
        measure(STAGES, DIV*p, "R2");
        if (h) measure(0, 2*p, "R2");
        repeat (5 + pause) @(posedge bsel);
        #2 out_en = 0;
        repeat (2) @(negedge bsel);
        #1 check("R6", clk_out, 0, "held low while stopped");
        repeat (pause * 3) @(posedge bsel);
        #1 check("R6", clk_out, 0, "still low after pause");
        #2 out_en = 1;        // model comparison checks resume from frozen phase
        repeat (3 * DIV + pause) @(posedge bsel);
    endtask

    initial begin
        #23;
        check("R7", clk_out, 0, "reset state");
        rst_n = 1;
        cmp_on = 1;
        for (int s = 0; s < 2; s++)
            for (int h = 0; h < 2; h++)
                for (int d = 1; d <= 3; d++)
                    scenario(bit'(s), bit'(h), d);
        check("R8", n_runt, 0, "runt pulses seen");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule